// File: doc/BRIEF.md
# Shared Descriptor Queue Pool

This block keeps packet descriptors for forty transmit queues in one common array of 128 entries. Every queue is a small circular FIFO, at most eight entries deep, that occupies a window of the array. Queues 0 to 7 each take their own window start and depth. Queues 8 to 39 form four groups of eight, and each group shares one start and one depth. Inside a group, the queues sit one after another, so queue k begins at group_start + (k - first_of_group) * group_depth. Window indices wrap modulo 128.

A producer pushes a descriptor word together with a queue number and a byte length. A consumer requests pops by queue number, and the head entry comes back one cycle later. For every queue the block keeps a running total of the bytes queued. When threshold gating is enabled, a queue withdraws its prefetch-ready signal once that total reaches its threshold. The threshold is given in 32-byte units: queues 0 to 7 each have their own, and queues 8 to 39 share one.

Two saturating statistics counters record discarded pushes and zero-length pushes. A host reads them over a small select/strobe port, and a read clears the counter it returns. In report mode, each successful pop also presents the queue number and its new read offset.

Top module: `dq_pool`

## Requirements
- R1: A push to a queue with free room is stored. A pop request that finds the queue non-empty raises `pop_vld` in the next cycle, with the descriptor and length of that queue's oldest entry, so each queue is served in FIFO order.
- R2: Queue q < 8 uses window start `cfg_own_base[q]` and depth `cfg_own_size[q]`. Queue q ≥ 8 belongs to group g = (q-8)/8 and starts at `cfg_grp_base[g] + ((q-8)%8) * cfg_grp_size[g]`, with all array indices taken modulo 128. Queues whose windows do not overlap never corrupt each other's entries.
- R3: A push to a queue already holding as many entries as its depth is discarded, and the drop counter (select 0) increments. A queue of depth 0 discards every push.
- R4: Every push with length 0 increments the zero-length counter (select 1), whatever its queue and whether or not it is stored.
- R5: A pop request to an empty queue changes no state. It raises `pop_unf` for exactly one cycle, in the cycle after the request, and `pop_vld` stays low in that cycle.
- R6: A push and a pop to the same queue in one cycle are both honoured. The pop frees a slot first, so a push to a full queue in that cycle is stored.
- R7: While `cfg_thr_en` is 1, `pf_ready[q]` is 0 exactly when the queue's byte total is at least threshold × 32. Queues 0-7 use `cfg_own_thr[q]`, and queues 8-39 use `cfg_grp_thr`. While `cfg_thr_en` is 0, every bit of `pf_ready` is 1.
- R8: A strobe on `st_rd` returns the selected counter on `st_data` in the next cycle and clears that counter. An event in the same cycle as the read is not lost: the counter restarts at 1 instead of 0.
- R9: Each counter stops at its all-ones value instead of wrapping.
- R10: While `cfg_rpt_en` is 1, each successful pop raises `rpt_vld` in the same cycle as `pop_vld`, with `rpt_qid` set to the queue and `rpt_off` set to its read offset after the pop (0 to depth-1 within the window). While `cfg_rpt_en` is 0, `rpt_vld` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_own_size | input | OWN_Q*SZ_W | Depth of queues 0-7, SZ_W bits each, queue 0 in the low bits |
| cfg_own_base | input | OWN_Q*IDX_W | Window start of queues 0-7 |
| cfg_grp_size | input | NGRP*SZ_W | Depth shared by each group of eight queues |
| cfg_grp_base | input | NGRP*IDX_W | Window start of each group |
| cfg_own_thr | input | OWN_Q*THR_W | Byte threshold of queues 0-7, in 32-byte units |
| cfg_grp_thr | input | THR_W | Byte threshold shared by queues 8-39 |
| cfg_thr_en | input | 1 | Enables threshold gating of `pf_ready` |
| cfg_rpt_en | input | 1 | Enables the read-offset report on each pop |
| push_vld | input | 1 | Push strobe |
| push_qid | input | QID_W | Queue number of the push |
| push_len | input | LEN_W | Packet byte length |
| push_desc | input | DESC_W | Descriptor word |
| pop_req | input | 1 | Pop request strobe |
| pop_qid | input | QID_W | Queue number of the pop |
| pop_vld | output | 1 | Popped entry valid |
| pop_desc | output | DESC_W | Popped descriptor |
| pop_len | output | LEN_W | Popped byte length |
| pop_unf | output | 1 | Pop hit an empty queue |
| rpt_vld | output | 1 | Read-offset report valid |
| rpt_qid | output | QID_W | Queue of the report |
| rpt_off | output | OFF_W | New read offset |
| pf_ready | output | NQ | Per-queue ready-to-prefetch |
| st_rd | input | 1 | Statistics read strobe |
| st_sel | input | 1 | 0 selects the drop counter, 1 the zero-length counter |
| st_data | output | CNT_W | Counter value read |

## Verification
The layout is first tried by filling every queue to its depth before any entry is read back. The fill includes a group whose windows wrap past index 127 onto the low entries. A mapping error shows up as a mismatched descriptor on some other queue. Overfilling each queue by one push, including the depth-0 queue, separates the full test from the empty test. Popping one past empty separates underflow from stale data. Combined push-and-pop cycles on a full queue and on an empty queue show whether the pop frees a slot before the push claims it. Byte pushes just below, exactly at and above a threshold, on an own-threshold queue and on grouped queues, tell the per-queue threshold from the shared one. Reading a counter in the same cycle as a new drop shows whether the clear loses that event.

// File: rtl/dqp_pkg.sv
package dqp_pkg;
    localparam int NQ_DEF      = 40;
    localparam int OWN_Q_DEF   = 8;
    localparam int GRP_Q_DEF   = 8;
    localparam int ENTRIES_DEF = 128;
    localparam int DEPTH_DEF   = 8;
    localparam int DESC_W_DEF  = 32;
    localparam int LEN_W_DEF   = 14;
    localparam int THR_W_DEF   = 12;
    localparam int CNT_W_DEF   = 16;

    typedef enum logic {
        STAT_DROP = 1'b0,
        STAT_ZERO = 1'b1
    } stat_sel_e;
endpackage

// File: rtl/dqp_layout.sv
module dqp_layout #(
    parameter int NQ    = 40,
    parameter int OWN_Q = 8,
    parameter int GRP_Q = 8,
    parameter int NGRP  = (NQ - OWN_Q) / GRP_Q,
    parameter int IDX_W = 7,
    parameter int SZ_W  = 4,
    parameter int THR_W = 12,
    parameter int QID_W = 6
) (
    input  logic [QID_W-1:0]       qid,
    input  logic [OWN_Q*SZ_W-1:0]  cfg_own_size,
    input  logic [OWN_Q*IDX_W-1:0] cfg_own_base,
    input  logic [NGRP*SZ_W-1:0]   cfg_grp_size,
    input  logic [NGRP*IDX_W-1:0]  cfg_grp_base,
    input  logic [OWN_Q*THR_W-1:0] cfg_own_thr,
    input  logic [THR_W-1:0]       cfg_grp_thr,
    output logic [IDX_W-1:0]       base,
    output logic [SZ_W-1:0]        size,
    output logic [THR_W-1:0]       thr
);
    always_comb begin
        int q;
        int g;
        int k;
        q    = int'(qid);
        g    = 0;
        k    = 0;
        base = '0;
        size = '0;
        thr  = cfg_grp_thr;
        if (q < OWN_Q) begin
            base = cfg_own_base[q*IDX_W +: IDX_W];
            size = cfg_own_size[q*SZ_W +: SZ_W];
            thr  = cfg_own_thr[q*THR_W +: THR_W];
        end else if (q < NQ) begin
            g    = (q - OWN_Q) / GRP_Q;
            k    = (q - OWN_Q) % GRP_Q;
            size = cfg_grp_size[g*SZ_W +: SZ_W];
            base = IDX_W'(int'(cfg_grp_base[g*IDX_W +: IDX_W]) + k * int'(size));
        end
    end
endmodule

// File: rtl/dqp_statcnt.sv
module dqp_statcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] val
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = inc ? W'(1) : '0;
        end else if (inc && (cnt_q != '1)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign val = cnt_q;

    // R9: an all-ones counter that is not cleared keeps its value
    p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == '1) && !clr) |=> (cnt_q == '1));
    // R8: after a clear the counter holds at most the one same-cycle event
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q <= W'(1)));
endmodule

// File: rtl/dq_pool.sv
module dq_pool
    import dqp_pkg::*;
#(
    parameter int NQ      = NQ_DEF,
    parameter int OWN_Q   = OWN_Q_DEF,
    parameter int GRP_Q   = GRP_Q_DEF,
    parameter int ENTRIES = ENTRIES_DEF,
    parameter int DEPTH   = DEPTH_DEF,
    parameter int DESC_W  = DESC_W_DEF,
    parameter int LEN_W   = LEN_W_DEF,
    parameter int THR_W   = THR_W_DEF,
    parameter int CNT_W   = CNT_W_DEF,
    parameter int NGRP    = (NQ - OWN_Q) / GRP_Q,
    parameter int QID_W   = $clog2(NQ),
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int OFF_W   = $clog2(DEPTH),
    parameter int SZ_W    = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [OWN_Q*SZ_W-1:0]  cfg_own_size,
    input  logic [OWN_Q*IDX_W-1:0] cfg_own_base,
    input  logic [NGRP*SZ_W-1:0]   cfg_grp_size,
    input  logic [NGRP*IDX_W-1:0]  cfg_grp_base,
    input  logic [OWN_Q*THR_W-1:0] cfg_own_thr,
    input  logic [THR_W-1:0]       cfg_grp_thr,
    input  logic                   cfg_thr_en,
    input  logic                   cfg_rpt_en,
    input  logic                   push_vld,
    input  logic [QID_W-1:0]       push_qid,
    input  logic [LEN_W-1:0]       push_len,
    input  logic [DESC_W-1:0]      push_desc,
    input  logic                   pop_req,
    input  logic [QID_W-1:0]       pop_qid,
    output logic                   pop_vld,
    output logic [DESC_W-1:0]      pop_desc,
    output logic [LEN_W-1:0]       pop_len,
    output logic                   pop_unf,
    output logic                   rpt_vld,
    output logic [QID_W-1:0]       rpt_qid,
    output logic [OFF_W-1:0]       rpt_off,
    output logic [NQ-1:0]          pf_ready,
    input  logic                   st_rd,
    input  logic                   st_sel,
    output logic [CNT_W-1:0]       st_data
);
    localparam int BYTES_W = LEN_W + $clog2(DEPTH + 1);
    localparam int WORD_W  = DESC_W + LEN_W;
    localparam int NSTAT   = 2;

    typedef struct packed {
        logic [NQ-1:0][OFF_W-1:0]   rd_off;
        logic [NQ-1:0][SZ_W-1:0]    cnt;
        logic [NQ-1:0][BYTES_W-1:0] bytes;
        logic                       pop_vld;
        logic                       pop_unf;
        logic [DESC_W-1:0]          pop_desc;
        logic [LEN_W-1:0]           pop_len;
        logic                       rpt_vld;
        logic [QID_W-1:0]           rpt_qid;
        logic [OFF_W-1:0]           rpt_off;
        logic [CNT_W-1:0]           st_data;
    } state_t;

    state_t s_d, s_q;
    logic [WORD_W-1:0] mem_q [ENTRIES];
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_word;

    logic [IDX_W-1:0] pop_base, push_base;
    logic [SZ_W-1:0]  pop_size, push_size;
    logic [THR_W-1:0] pop_thr_unused, push_thr_unused;

    logic [NSTAT-1:0]            st_inc, st_clr;
    logic [NSTAT-1:0][CNT_W-1:0] st_val;

    dqp_layout #(.NQ(NQ), .OWN_Q(OWN_Q), .GRP_Q(GRP_Q), .NGRP(NGRP), .IDX_W(IDX_W),
                 .SZ_W(SZ_W), .THR_W(THR_W), .QID_W(QID_W)) u_pop_map (
        .qid(pop_qid), .cfg_own_size(cfg_own_size), .cfg_own_base(cfg_own_base),
        .cfg_grp_size(cfg_grp_size), .cfg_grp_base(cfg_grp_base),
        .cfg_own_thr(cfg_own_thr), .cfg_grp_thr(cfg_grp_thr),
        .base(pop_base), .size(pop_size), .thr(pop_thr_unused));

    dqp_layout #(.NQ(NQ), .OWN_Q(OWN_Q), .GRP_Q(GRP_Q), .NGRP(NGRP), .IDX_W(IDX_W),
                 .SZ_W(SZ_W), .THR_W(THR_W), .QID_W(QID_W)) u_push_map (
        .qid(push_qid), .cfg_own_size(cfg_own_size), .cfg_own_base(cfg_own_base),
        .cfg_grp_size(cfg_grp_size), .cfg_grp_base(cfg_grp_base),
        .cfg_own_thr(cfg_own_thr), .cfg_grp_thr(cfg_grp_thr),
        .base(push_base), .size(push_size), .thr(push_thr_unused));

    always_comb begin
        int pq;
        int uq;
        logic            pop_ok;
        logic            push_ok;
        logic [SZ_W-1:0] nxt;
        logic [SZ_W:0]   tail;
        logic [WORD_W-1:0] head;
        pq      = (int'(pop_qid) < NQ) ? int'(pop_qid) : 0;
        uq      = (int'(push_qid) < NQ) ? int'(push_qid) : 0;
        s_d     = s_q;
        s_d.pop_vld = 1'b0;
        s_d.pop_unf = 1'b0;
        s_d.rpt_vld = 1'b0;
        wr_en   = 1'b0;
        wr_idx  = '0;
        wr_word = '0;
        nxt     = '0;
        tail    = '0;
        head    = mem_q[pop_base + IDX_W'(s_q.rd_off[pq])];

        // pop side acts first so a same-cycle push sees the freed slot
        pop_ok = pop_req && (int'(pop_qid) < NQ) && (s_q.cnt[pq] != '0);
        if (pop_req && !pop_ok) begin
            s_d.pop_unf = 1'b1;
        end
        if (pop_ok) begin
            nxt = SZ_W'(s_q.rd_off[pq]) + SZ_W'(1);
            if (nxt >= pop_size) nxt = '0;
            s_d.rd_off[pq] = OFF_W'(nxt);
            s_d.cnt[pq]    = s_q.cnt[pq] - SZ_W'(1);
            s_d.bytes[pq]  = s_q.bytes[pq] - BYTES_W'(head[LEN_W-1:0]);
            s_d.pop_vld    = 1'b1;
            s_d.pop_desc   = head[WORD_W-1:LEN_W];
            s_d.pop_len    = head[LEN_W-1:0];
            s_d.rpt_vld    = cfg_rpt_en;
            s_d.rpt_qid    = pop_qid;
            s_d.rpt_off    = OFF_W'(nxt);
        end

        push_ok = push_vld && (int'(push_qid) < NQ) && (s_d.cnt[uq] < push_size);
        if (push_ok) begin
            tail = (SZ_W+1)'(s_q.rd_off[uq]) + (SZ_W+1)'(s_q.cnt[uq]);
            if (tail >= (SZ_W+1)'(push_size)) tail = tail - (SZ_W+1)'(push_size);
            wr_en         = 1'b1;
            wr_idx        = push_base + IDX_W'(tail);
            wr_word       = {push_desc, push_len};
            s_d.cnt[uq]   = s_d.cnt[uq] + SZ_W'(1);
            s_d.bytes[uq] = s_d.bytes[uq] + BYTES_W'(push_len);
        end

        st_inc[STAT_DROP] = push_vld && !push_ok;
        st_inc[STAT_ZERO] = push_vld && (push_len == '0);
        st_clr[STAT_DROP] = st_rd && (stat_sel_e'(st_sel) == STAT_DROP);
        st_clr[STAT_ZERO] = st_rd && (stat_sel_e'(st_sel) == STAT_ZERO);
        if (st_rd) s_d.st_data = st_val[st_sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_word;
    end

    generate
        for (genvar c = 0; c < NSTAT; c++) begin : g_stat
            dqp_statcnt #(.W(CNT_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .inc(st_inc[c]), .clr(st_clr[c]), .val(st_val[c]));
        end
        for (genvar i = 0; i < NQ; i++) begin : g_ready
            logic [THR_W-1:0] thr_i;
            if (i < OWN_Q) begin : g_own
                assign thr_i = cfg_own_thr[i*THR_W +: THR_W];
            end else begin : g_grp
                assign thr_i = cfg_grp_thr;
            end
            assign pf_ready[i] = !(cfg_thr_en && (32'(s_q.bytes[i]) >= (32'(thr_i) << 5)));

            // R3: occupancy never exceeds the largest depth
            p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
                s_q.cnt[i] <= SZ_W'(DEPTH));
        end
    endgenerate

    assign pop_vld  = s_q.pop_vld;
    assign pop_desc = s_q.pop_desc;
    assign pop_len  = s_q.pop_len;
    assign pop_unf  = s_q.pop_unf;
    assign rpt_vld  = s_q.rpt_vld;
    assign rpt_qid  = s_q.rpt_qid;
    assign rpt_off  = s_q.rpt_off;
    assign st_data  = s_q.st_data;

    // R1: popped data only follows a request
    p_pop_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pop_vld |-> $past(pop_req));
    // R5: underflow only follows a request and never with data
    p_unf_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_unf |-> ($past(pop_req) && !pop_vld));
    // R10: a report accompanies a real pop
    p_rpt_with_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_vld |-> pop_vld);
    // R10: no report while the mode was off
    p_rpt_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_rpt_en) |-> !rpt_vld);
endmodule

// File: tb/sim_dq_pool.sv
`timescale 1ns/1ps
module sim_dq_pool;
    localparam int NQ = 40;
    localparam int CNT_W = 4;
    localparam int CMAX = 15;

    typedef struct packed {
        logic        unf;
        logic [31:0] desc;
        logic [13:0] len;
        logic        rpt;
        logic [5:0]  q;
        logic [2:0]  off;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] cfg_own_size;
    logic [55:0] cfg_own_base;
    logic [15:0] cfg_grp_size;
    logic [27:0] cfg_grp_base;
    logic [95:0] cfg_own_thr;
    logic [11:0] cfg_grp_thr;
    logic cfg_thr_en, cfg_rpt_en;
    logic push_vld, pop_req, st_rd, st_sel;
    logic [5:0] push_qid, pop_qid;
    logic [13:0] push_len;
    logic [31:0] push_desc;
    logic pop_vld, pop_unf, rpt_vld;
    logic [31:0] pop_desc;
    logic [13:0] pop_len;
    logic [5:0] rpt_qid;
    logic [2:0] rpt_off;
    logic [NQ-1:0] pf_ready;
    logic [CNT_W-1:0] st_data;

    dq_pool #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_own_size(cfg_own_size), .cfg_own_base(cfg_own_base),
        .cfg_grp_size(cfg_grp_size), .cfg_grp_base(cfg_grp_base),
        .cfg_own_thr(cfg_own_thr), .cfg_grp_thr(cfg_grp_thr),
        .cfg_thr_en(cfg_thr_en), .cfg_rpt_en(cfg_rpt_en),
        .push_vld(push_vld), .push_qid(push_qid), .push_len(push_len), .push_desc(push_desc),
        .pop_req(pop_req), .pop_qid(pop_qid),
        .pop_vld(pop_vld), .pop_desc(pop_desc), .pop_len(pop_len), .pop_unf(pop_unf),
        .rpt_vld(rpt_vld), .rpt_qid(rpt_qid), .rpt_off(rpt_off),
        .pf_ready(pf_ready), .st_rd(st_rd), .st_sel(st_sel), .st_data(st_data));

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int own_sz[8] = '{3, 8, 0, 2, 2, 2, 2, 2};
    int own_bs[8] = '{4, 7, 15, 15, 17, 19, 21, 23};
    int own_th[8] = '{2, 4095, 4095, 4095, 4095, 4095, 4095, 4095};
    int grp_sz[4] = '{2, 3, 4, 1};
    int grp_bs[4] = '{25, 41, 65, 124};
    int grp_th = 1;
    logic [45:0] mq[NQ][$];
    int rdo[NQ];
    int bytes_m[NQ];
    int m_drop = 0;
    int m_zero = 0;
    exp_t expq[$];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int qsize(int q);
        if (q < 8) return own_sz[q];
        return grp_sz[(q - 8) / 8];
    endfunction

    function automatic int qthr(int q);
        if (q < 8) return own_th[q];
        return grp_th;
    endfunction

    task automatic step(bit pv, int pq, int plen, logic [31:0] pd, bit rq, int rqq);
        exp_t e;
        logic [45:0] w;
        push_vld = pv; push_qid = 6'(pq); push_len = 14'(plen); push_desc = pd;
        pop_req = rq; pop_qid = 6'(rqq);
        if (rq) begin
            e = '0;
            if (mq[rqq].size() > 0) begin
                w = mq[rqq].pop_front();
                e.desc = w[45:14];
                e.len = w[13:0];
                bytes_m[rqq] -= int'(w[13:0]);
                rdo[rqq] = (rdo[rqq] + 1) % qsize(rqq);
                e.rpt = cfg_rpt_en;
                e.q = 6'(rqq);
                e.off = 3'(rdo[rqq]);
            end else begin
                e.unf = 1'b1;
            end
            expq.push_back(e);
        end
        if (pv) begin
            if (plen == 0 && m_zero < CMAX) m_zero++;
            if (mq[pq].size() < qsize(pq)) begin
                mq[pq].push_back({pd, 14'(plen)});
                bytes_m[pq] += plen;
            end else if (m_drop < CMAX) begin
                m_drop++;
            end
        end
        @(negedge clk);
        push_vld = 1'b0;
        pop_req = 1'b0;
    endtask

    task automatic rd_stat(bit sel, string req);
        int expv;
        expv = sel ? m_zero : m_drop;
        st_rd = 1'b1; st_sel = sel;
        @(negedge clk);
        st_rd = 1'b0;
        chk(st_data == CNT_W'(expv), req, sel ? "zero-length count" : "drop count",
            st_data, expv);
        if (sel) m_zero = 0; else m_drop = 0;
    endtask

    task automatic check_ready(string req);
        logic [NQ-1:0] expv;
        for (int q = 0; q < NQ; q++)
            expv[q] = !(cfg_thr_en && bytes_m[q] >= qthr(q) * 32);
        chk(pf_ready == expv, req, "pf_ready", pf_ready, expv);
    endtask

    // monitor: compares each pop result against the scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && (pop_vld || pop_unf)) begin
            if (expq.size() == 0) begin
                chk(0, "R1", "unexpected pop output", 1, 0);
            end else begin
                e = expq.pop_front();
                if (e.unf) begin
                    chk(pop_unf && !pop_vld && !rpt_vld, "R5", "underflow flag", pop_unf, 1);
                end else begin
                    chk(pop_vld && pop_desc == e.desc && pop_len == e.len, "R1",
                        "popped descriptor", pop_desc, e.desc);
                    chk(rpt_vld == e.rpt, "R10", "report valid", rpt_vld, e.rpt);
                    if (e.rpt)
                        chk(rpt_qid == e.q && rpt_off == e.off, "R10", "report offset",
                            {rpt_qid, rpt_off}, {e.q, e.off});
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            cfg_own_size[i*4 +: 4] = 4'(own_sz[i]);
            cfg_own_base[i*7 +: 7] = 7'(own_bs[i]);
            cfg_own_thr[i*12 +: 12] = 12'(own_th[i]);
        end
        for (int g = 0; g < 4; g++) begin
            cfg_grp_size[g*4 +: 4] = 4'(grp_sz[g]);
            cfg_grp_base[g*7 +: 7] = 7'(grp_bs[g]);
        end
        cfg_grp_thr = 12'(grp_th);
        cfg_thr_en = 0; cfg_rpt_en = 0;
        push_vld = 0; push_qid = 0; push_len = 0; push_desc = 0;
        pop_req = 0; pop_qid = 0; st_rd = 0; st_sel = 0;
        for (int q = 0; q < NQ; q++) begin rdo[q] = 0; bytes_m[q] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(pop_vld == 0 && pop_unf == 0, "R1", "pop outputs after reset", pop_vld, 0);
        check_ready("R7");
        rd_stat(0, "R8");

        // R3: overfill queue 0 by one
        for (int j = 0; j < 4; j++) step(1, 0, 16 + j, {8'd0, 8'(j), 16'hA500}, 0, 0);
        rd_stat(0, "R3");
        // R2: fill every other queue one past its depth, windows of group 3 wrap
        for (int q = 1; q < NQ; q++)
            for (int j = 0; j <= qsize(q); j++)
                step(1, q, 16 + q + j, {8'(q), 8'(j), 16'h5A00}, 0, 0);
        rd_stat(0, "R9");
        // R1 R2 R5: drain each queue plus one extra pop
        for (int q = 0; q < NQ; q++)
            for (int j = 0; j <= qsize(q); j++) step(0, 0, 0, 0, 1, q);
        rd_stat(1, "R4");

        // R6: full queue 1, push and pop together
        for (int j = 0; j < 8; j++) step(1, 1, 100 + j, {16'h0101, 16'(j)}, 0, 0);
        step(1, 1, 200, 32'hBEEF0001, 1, 1);
        for (int j = 0; j < 8; j++) step(0, 0, 0, 0, 1, 1);
        // R6: empty queue 0, push and pop together
        step(1, 0, 50, 32'hBEEF0002, 1, 0);
        step(0, 0, 0, 0, 1, 0);
        rd_stat(0, "R6");

        // R7: threshold gating
        cfg_thr_en = 1;
        @(negedge clk);
        check_ready("R7");
        step(1, 0, 40, 32'hC0, 0, 0);  check_ready("R7");
        step(1, 0, 24, 32'hC1, 0, 0);  check_ready("R7");
        step(1, 9, 32, 32'hC2, 0, 0);  check_ready("R7");
        step(1, 33, 31, 32'hC3, 0, 0); check_ready("R7");
        step(0, 0, 0, 0, 1, 0);        check_ready("R7");
        cfg_thr_en = 0;
        @(negedge clk);
        check_ready("R7");
        step(0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 1, 9);
        step(0, 0, 0, 0, 1, 33);

        // R4: zero-length pushes on several queues, one into a depth-0 queue
        step(1, 5, 0, 32'hD5, 0, 0);
        step(1, 20, 0, 32'hD20, 0, 0);
        step(1, 2, 0, 32'hD2, 0, 0);
        rd_stat(1, "R4");
        rd_stat(0, "R3");
        step(0, 0, 0, 0, 1, 5);
        step(0, 0, 0, 0, 1, 20);

        // R10: report mode on
        cfg_rpt_en = 1;
        for (int j = 0; j < 3; j++) step(1, 1, 60 + j, {16'h1010, 16'(j)}, 0, 0);
        for (int j = 0; j < 3; j++) step(0, 0, 0, 0, 1, 1);
        for (int j = 0; j < 3; j++) step(1, 10, 70 + j, {16'h1A1A, 16'(j)}, 0, 0);
        for (int j = 0; j < 2; j++) step(0, 0, 0, 0, 1, 10);
        cfg_rpt_en = 0;
        step(1, 3, 77, 32'hE3, 0, 0);
        step(0, 0, 0, 0, 1, 3);

        // R8: read the drop counter while a new drop happens
        st_rd = 1'b1; st_sel = 1'b0;
        begin
            int old;
            old = m_drop;
            m_drop = 0;
            step(1, 2, 5, 32'hF2, 0, 0);
            st_rd = 1'b0;
            chk(st_data == CNT_W'(old), "R8", "value returned by read", st_data, old);
        end
        rd_stat(0, "R8");

        // R9: saturation
        for (int j = 0; j < 20; j++) step(1, 2, 9, 32'h99, 0, 0);
        rd_stat(0, "R9");
        rd_stat(0, "R9");

        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R1", "pending expected pops", expq.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule